// File: doc/BRIEF.md
# Instruction-Side Fault Status Register

This block holds a 32-bit status word. The word records why the most recent instruction fetch was aborted. Software reaches the word through a coprocessor register access port. Each access carries four selector fields, a read/write flag, the current processor mode and write data. The fetch path reports an abort on a separate input, which carries a valid strobe and a 4-bit cause code.

Only the low four bits hold state. The other bits of the word always read as zero, and written values for those bits are discarded. A privileged access at the register's own coordinate reads the stored cause, or overwrites it so that a debugger can put back a saved value. The same access made from user mode leaves the register alone and signals an undefined-instruction trap. Accesses at other coordinates get no answer from this block, so that other decoders on the port can serve them. A fault report with a meaningful cause replaces the stored code, so the most recent fault is the one kept. A fault report with a reserved code is dropped.

All responses are registered. A response appears in the cycle after the access strobe. A read returns the value that was stored before that clock edge.

Top module: `ifsr_unit`

## Requirements
- R1: After reset the stored cause is 4'b0000, `rsp_rvalid` and `rsp_undef` are low, and `rsp_rdata` is zero.
- R2: The register is selected only when op1 = 0, crn = 5, crm = 0 and op2 = 1. An access with any other selector values produces no `rsp_rvalid`, no `rsp_undef` and zero `rsp_rdata` in the next cycle, and it does not change the stored cause.
- R3: A privileged read at the register's coordinate gives `rsp_rvalid` = 1 in the next cycle, with `rsp_rdata` = {28'b0, cause}. The cause returned is the one held before that clock edge.
- R4: A privileged write at the register's coordinate stores `acc_wdata[3:0]` and discards `acc_wdata[31:4]`. The new value is returned by a read issued in any later cycle.
- R5: The mode value 5'b10000 is user mode. Every other mode value is privileged. An access from user mode at the register's coordinate raises `rsp_undef` in the next cycle, with `rsp_rvalid` low and `rsp_rdata` zero, and it does not change the stored cause.
- R6: When `flt_valid` is high with a non-reserved cause, the stored cause becomes `flt_cause` at that clock edge. Each later fault overwrites the previous one.
- R7: The cause codes 4'b0000, 4'b0100 and 4'b1010 are reserved. A fault report that carries one of them leaves the stored cause unchanged.
- R8: If a valid non-reserved fault report and a privileged write arrive in the same cycle, the fault cause is stored and the written data is lost.
- R9: `rsp_rdata[31:4]` is always zero, and all of `rsp_rdata` is zero whenever `rsp_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access strobe on the coprocessor port |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op1 | input | 3 | First opcode selector |
| acc_crn | input | 4 | Primary register selector |
| acc_crm | input | 4 | Secondary register selector |
| acc_op2 | input | 3 | Second opcode selector |
| acc_mode | input | 5 | Processor mode; 5'b10000 is user mode |
| acc_wdata | input | 32 | Write data |
| flt_valid | input | 1 | Instruction fault report strobe |
| flt_cause | input | 4 | Reported fault cause |
| rsp_rdata | output | 32 | Read data, valid with `rsp_rvalid` |
| rsp_rvalid | output | 1 | Read response from this register |
| rsp_undef | output | 1 | Undefined-instruction trap for a disallowed access |

## Verification
The stored cause cannot be seen directly. If it is corrupted by a missed fault, a wrongly accepted reserved code, a user-mode write or a lost priority, the error shows only on the next privileged read, one cycle after that read's strobe. For this reason the stimulus issues reads often, with about half of all accesses hitting the register's coordinate. A corrupted value then reaches the ports within a few cycles of the step that caused it. A decode or privilege fault is visible sooner: it shows in the very next cycle as a wrong `rsp_rvalid` or `rsp_undef`.

// File: rtl/ifsr_pkg.sv
// Package: shared constants, the coordinate type and the cause helper
// for the instruction fault status register.
// Assumes a 5-bit mode field in which exactly one code means user mode.
package ifsr_pkg;

    localparam int unsigned MODE_W = 5;
    localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
    localparam int unsigned CAUSE_W = 4;

    typedef struct packed {
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } cp_coord_t;

    localparam cp_coord_t IFSR_COORD = '{op1: 3'd0, crn: 4'd5, crm: 4'd0, op2: 3'd1};

    // Returns 1 for cause codes that carry no meaning on the fetch side.
    function automatic logic cause_is_reserved(input logic [CAUSE_W-1:0] c);
        return (c == 4'b0000) || (c == 4'b0100) || (c == 4'b1010);
    endfunction

endpackage

// File: rtl/ifsr_coord_match.sv
// Module: compares an access coordinate with the fixed coordinate of
// this register.
// Assumes that all four selector fields must match exactly.
module ifsr_coord_match
    import ifsr_pkg::*;
#(
    parameter cp_coord_t HIT_AT = IFSR_COORD
) (
    input  cp_coord_t coord,
    output logic      hit
);

    // Full equality on every field of the coordinate.
    always_comb begin
        hit = (coord.op1 == HIT_AT.op1) &&
              (coord.crn == HIT_AT.crn) &&
              (coord.crm == HIT_AT.crm) &&
              (coord.op2 == HIT_AT.op2);
    end

endmodule

// File: rtl/ifsr_priv_gate.sv
// Module: splits a decoded access into a read enable, a write enable
// or a trap, depending on the processor mode.
// Assumes that every mode other than user mode is privileged.
module ifsr_priv_gate
    import ifsr_pkg::*;
(
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              hit,
    input  logic [MODE_W-1:0] mode,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              trap
);

    logic is_user;
    logic take;

    // Classifies the mode and qualifies the access strobe with the decode.
    always_comb begin
        is_user = (mode == MODE_USER);
        take    = acc_valid && hit;
    end

    // Grants a privileged access and turns a user access into a trap.
    always_comb begin
        rd_ok = take && !is_user && !acc_write;
        wr_ok = take && !is_user &&  acc_write;
        trap  = take &&  is_user;
    end

endmodule

// File: rtl/ifsr_status_store.sv
// Module: holds the cause code. A valid fault report with a
// non-reserved cause has priority over a privileged write.
// Assumes that the write data has already been reduced to the cause width.
module ifsr_status_store
    import ifsr_pkg::*;
#(
    parameter int unsigned STAT_W = CAUSE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [STAT_W-1:0] wr_cause,
    input  logic              flt_valid,
    input  logic [STAT_W-1:0] flt_cause,
    output logic [STAT_W-1:0] stat_q
);

    logic              flt_take;
    logic [STAT_W-1:0] stat_d;

    // Accepts only fault reports whose cause is not reserved.
    always_comb begin
        flt_take = flt_valid && !cause_is_reserved(flt_cause);
    end

    // Next-state selection: the fault wins, then the write, otherwise hold.
    always_comb begin
        if (flt_take) begin
            stat_d = flt_cause;
        end else if (wr_ok) begin
            stat_d = wr_cause;
        end else begin
            stat_d = stat_q;
        end
    end

    // The cause register, cleared to the "nothing recorded" code on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

endmodule

// File: rtl/ifsr_resp_reg.sv
// Module: registers the port response: read data padded with zeros,
// the read-valid flag and the trap flag.
// Assumes that rd_ok and trap are never high together.
module ifsr_resp_reg
    import ifsr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STAT_W = CAUSE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ok,
    input  logic              trap,
    input  logic [STAT_W-1:0] stat_q,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_rvalid,
    output logic              rsp_undef
);

    localparam int unsigned PAD_W = DATA_W - STAT_W;

    logic [DATA_W-1:0] rdata_d;

    // Forms the read word: zero padding above the cause, zero when idle.
    always_comb begin
        rdata_d = rd_ok ? {{PAD_W{1'b0}}, stat_q} : '0;
    end

    // Response registers, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata  <= '0;
            rsp_rvalid <= 1'b0;
            rsp_undef  <= 1'b0;
        end else begin
            rsp_rdata  <= rdata_d;
            rsp_rvalid <= rd_ok;
            rsp_undef  <= trap;
        end
    end

endmodule

// File: rtl/ifsr_unit.sv
// Module: top of the instruction fault status register. It ties together
// the coordinate decode, the privilege gate, the cause store and the
// response register.
// Assumes a single-cycle access strobe. The response arrives one cycle later.
module ifsr_unit
    import ifsr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [2:0]        acc_op1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op2,
    input  logic [MODE_W-1:0] acc_mode,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              flt_valid,
    input  logic [CAUSE_W-1:0] flt_cause,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_rvalid,
    output logic              rsp_undef
);

    cp_coord_t          coord;
    logic               hit;
    logic               rd_ok;
    logic               wr_ok;
    logic               trap;
    logic [CAUSE_W-1:0] stat_q;
    logic [CAUSE_W-1:0] wr_cause;
    logic               wdata_hi_unused;

    // Gathers the selector fields and splits the write data.
    always_comb begin
        coord           = '{op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};
        wr_cause        = acc_wdata[CAUSE_W-1:0];
        wdata_hi_unused = ^acc_wdata[DATA_W-1:CAUSE_W];
    end

    ifsr_coord_match #(.HIT_AT(IFSR_COORD)) i_match (
        .coord (coord),
        .hit   (hit)
    );

    ifsr_priv_gate i_gate (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .hit       (hit),
        .mode      (acc_mode),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .trap      (trap)
    );

    ifsr_status_store #(.STAT_W(CAUSE_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .wr_cause  (wr_cause),
        .flt_valid (flt_valid),
        .flt_cause (flt_cause),
        .stat_q    (stat_q)
    );

    ifsr_resp_reg #(.DATA_W(DATA_W), .STAT_W(CAUSE_W)) i_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_ok      (rd_ok),
        .trap       (trap),
        .stat_q     (stat_q),
        .rsp_rdata  (rsp_rdata),
        .rsp_rvalid (rsp_rvalid),
        .rsp_undef  (rsp_undef)
    );

endmodule

// File: rtl/ifsr_unit_chk.sv
// Checker: temporal properties of ifsr_unit, attached to it by bind.
// Assumes the default 32-bit data width and the fixed register coordinate.
module ifsr_unit_chk
    import ifsr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [2:0]         acc_op1,
    input logic [3:0]         acc_crn,
    input logic [3:0]         acc_crm,
    input logic [2:0]         acc_op2,
    input logic [MODE_W-1:0]  acc_mode,
    input logic               flt_valid,
    input logic [CAUSE_W-1:0] flt_cause,
    input logic [CAUSE_W-1:0] stat_q,
    input logic [31:0]        rsp_rdata,
    input logic               rsp_rvalid,
    input logic               rsp_undef
);

    logic at_reg;
    logic priv;

    // Access classification seen from the ports.
    always_comb begin
        at_reg = (acc_op1 == 3'd0) && (acc_crn == 4'd5) && (acc_crm == 4'd0) && (acc_op2 == 3'd1);
        priv   = (acc_mode != MODE_USER);
    end

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rsp_rdata[31:4] == 28'd0); // R9
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !rsp_rvalid |-> (rsp_rdata == 32'd0)); // R9
    AST_OFF_COORD_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (acc_valid && !at_reg) |=> (!rsp_rvalid && !rsp_undef)); // R2
    AST_USER_TRAPS: assert property (@(posedge clk) disable iff (!rst_n) (acc_valid && at_reg && !priv) |=> (rsp_undef && !rsp_rvalid)); // R5
    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n) (acc_valid && at_reg && priv && !acc_write) |=> (rsp_rvalid && rsp_rdata[3:0] == $past(stat_q))); // R3
    AST_FAULT_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (flt_valid && !cause_is_reserved(flt_cause)) |=> (stat_q == $past(flt_cause))); // R6
    AST_RSVD_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (flt_valid && cause_is_reserved(flt_cause) && !(acc_valid && acc_write && at_reg && priv)) |=> $stable(stat_q)); // R7
    AST_USER_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n) (acc_valid && at_reg && !priv && !flt_valid) |=> $stable(stat_q)); // R5
    AST_NO_DUAL_RESP: assert property (@(posedge clk) disable iff (!rst_n) !(rsp_rvalid && rsp_undef)); // R3

endmodule

bind ifsr_unit ifsr_unit_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_op1    (acc_op1),
    .acc_crn    (acc_crn),
    .acc_crm    (acc_crm),
    .acc_op2    (acc_op2),
    .acc_mode   (acc_mode),
    .flt_valid  (flt_valid),
    .flt_cause  (flt_cause),
    .stat_q     (stat_q),
    .rsp_rdata  (rsp_rdata),
    .rsp_rvalid (rsp_rvalid),
    .rsp_undef  (rsp_undef)
);

// File: tb/test_ifsr_unit.sv
`timescale 1ns/1ps
module test_ifsr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_op1 = '0;
    logic [3:0]  acc_crn = '0;
    logic [3:0]  acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic [4:0]  acc_mode = 5'b10011;
    logic [31:0] acc_wdata = '0;
    logic        flt_valid = 1'b0;
    logic [3:0]  flt_cause = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_rvalid;
    logic        rsp_undef;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    logic [3:0] model = 4'd0;

    localparam logic [4:0] USR = 5'b10000;
    localparam logic [4:0] SVC = 5'b10011;

    always #4 clk = ~clk;

    ifsr_unit i_ifsr_unit (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
        .acc_mode(acc_mode), .acc_wdata(acc_wdata), .flt_valid(flt_valid),
        .flt_cause(flt_cause), .rsp_rdata(rsp_rdata), .rsp_rvalid(rsp_rvalid),
        .rsp_undef(rsp_undef)
    );

    function automatic bit rsvd(input logic [3:0] c);
        return (c == 4'd0) || (c == 4'd4) || (c == 4'd10);
    endfunction

    function automatic bit at_coord(input logic [2:0] o1, input logic [3:0] n,
                                    input logic [3:0] m, input logic [2:0] o2);
        return (o1 == 3'd0) && (n == 4'd5) && (m == 4'd0) && (o2 == 3'd1);
    endfunction

    task automatic check(input string tag, input logic [31:0] ed, input logic ev, input logic eu);
        n_cmp++;
        if (rsp_rdata !== ed || rsp_rvalid !== ev || rsp_undef !== eu) begin
            n_bad++;
            $display("FAIL %s: got rdata=%h rvalid=%b undef=%b, want rdata=%h rvalid=%b undef=%b",
                     tag, rsp_rdata, rsp_rvalid, rsp_undef, ed, ev, eu);
        end
    endtask

    // One cycle: drive at the falling edge, predict, update the model, check at the next falling edge.
    task automatic step(input string tag, input logic v, input logic w,
                        input logic [2:0] o1, input logic [3:0] n, input logic [3:0] m,
                        input logic [2:0] o2, input logic [4:0] md, input logic [31:0] wd,
                        input logic fv, input logic [3:0] fc);
        logic hitc, priv, ev, eu;
        logic [31:0] ed;
        acc_valid = v; acc_write = w; acc_op1 = o1; acc_crn = n; acc_crm = m;
        acc_op2 = o2; acc_mode = md; acc_wdata = wd; flt_valid = fv; flt_cause = fc;
        hitc = v && at_coord(o1, n, m, o2);
        priv = (md != USR);
        ev = hitc && priv && !w;
        eu = hitc && !priv;
        ed = ev ? {28'd0, model} : 32'd0;
        if (fv && !rsvd(fc)) model = fc;
        else if (hitc && priv && w) model = wd[3:0];
        @(posedge clk);
        @(negedge clk);
        check(tag, ed, ev, eu);
    endtask

    task automatic rd(input string tag);
        step(tag, 1, 0, 3'd0, 4'd5, 4'd0, 3'd1, SVC, 32'd0, 0, 4'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got cycle=%0d, want completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", 32'd0, 0, 0);
        rd("R1 reset cause");

        // R4: write keeps only the low bits
        step("R4 write", 1, 1, 3'd0, 4'd5, 4'd0, 3'd1, SVC, 32'hFFFF_FFF7, 0, 4'd0);
        rd("R4 readback");
        // R2: near-miss coordinates do nothing
        step("R2 op2 miss", 1, 1, 3'd0, 4'd5, 4'd0, 3'd0, SVC, 32'h3, 0, 4'd0);
        step("R2 crm miss", 1, 0, 3'd0, 4'd5, 4'd1, 3'd1, SVC, 32'h0, 0, 4'd0);
        step("R2 op1 miss", 1, 1, 3'd1, 4'd5, 4'd0, 3'd1, USR, 32'h9, 0, 4'd0);
        rd("R2 state kept");
        // R5: user mode traps and does not write
        step("R5 user write", 1, 1, 3'd0, 4'd5, 4'd0, 3'd1, USR, 32'h2, 0, 4'd0);
        step("R5 user read", 1, 0, 3'd0, 4'd5, 4'd0, 3'd1, USR, 32'h0, 0, 4'd0);
        rd("R5 state kept");
        // R6: fault capture, last one wins
        step("R6 fault a", 0, 0, 3'd0, 4'd0, 4'd0, 3'd0, SVC, 32'h0, 1, 4'd1);
        step("R6 fault b", 0, 0, 3'd0, 4'd0, 4'd0, 3'd0, SVC, 32'h0, 1, 4'd15);
        rd("R6 last fault");
        // R7: reserved causes are dropped
        step("R7 rsvd 0", 0, 0, 3'd0, 4'd0, 4'd0, 3'd0, SVC, 32'h0, 1, 4'd0);
        step("R7 rsvd 4", 0, 0, 3'd0, 4'd0, 4'd0, 3'd0, SVC, 32'h0, 1, 4'd4);
        step("R7 rsvd 10", 0, 0, 3'd0, 4'd0, 4'd0, 3'd0, SVC, 32'h0, 1, 4'd10);
        rd("R7 state kept");
        // R8: fault beats a same-cycle write
        step("R8 collide", 1, 1, 3'd0, 4'd5, 4'd0, 3'd1, SVC, 32'h6, 1, 4'd12);
        rd("R8 fault kept");
        // R8 companion: a reserved fault does not block the write
        step("R8 rsvd+write", 1, 1, 3'd0, 4'd5, 4'd0, 3'd1, SVC, 32'h9, 1, 4'd4);
        rd("R8 write kept");
        // R3: read sees the pre-edge value while a fault lands
        step("R3 read+fault", 1, 0, 3'd0, 4'd5, 4'd0, 3'd1, SVC, 32'h0, 1, 4'd5);
        rd("R3 new value");

        for (int i = 0; i < 4000; i++) begin
            logic v, w, fv, h;
            logic [2:0] o1, o2;
            logic [3:0] n, m, fc;
            logic [4:0] md;
            string tg;
            v  = ($urandom % 4) != 0;
            w  = $urandom % 2;
            h  = ($urandom % 2) == 0;
            o1 = h ? 3'd0 : 3'($urandom);
            n  = h ? 4'd5 : 4'($urandom);
            m  = h ? 4'd0 : 4'($urandom);
            o2 = h ? 3'd1 : 3'($urandom);
            md = (($urandom % 3) == 0) ? USR : 5'($urandom | 5'b10001);
            fv = ($urandom % 4) == 0;
            fc = 4'($urandom);
            if (!(v && at_coord(o1, n, m, o2))) tg = "R2 random off/idle";
            else if (md == USR) tg = "R5 random user";
            else if (w) tg = "R4 random write";
            else tg = "R3 random read";
            step(tg, v, w, o1, n, m, o2, md, $urandom, fv, fc);
        end
        rd("R9 final read");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule